// File: doc/BRIEF.md
# Configurable Multiplexer Logic Cell with Optional Storage

This block is one programmable logic cell. Its function comes from a 4-to-1 multiplexer on WIDTH-bit data lanes that share two select lines. A 3-bit configuration code decides how the multiplexer result reaches the output. It can go straight through, be registered on the rising edge of the clock/gate input, or be held in a level-sensitive latch. The latch either obeys the active-low clear or ignores it. A reduced setting swaps the 4-to-1 multiplexer for a 2-to-1 multiplexer that feeds the clearable latch.

The configuration is static. It is loaded before use and held while the cell operates. Several cells are placed side by side in a fabric, and the routing and the logic that loads the configuration sit outside the cell.

Top module: `mux_store_cell`

## Requirements
- R1: The wide multiplexer picks one data word by {selHi, selLo}, with selHi as the more significant bit: 00 gives dIn00, 01 gives dIn01, 10 gives dIn10, 11 gives dIn11.
- R2: With cellMode = 0 the multiplexer result drives cellOut combinationally, whatever gateClk and clearN are doing.
- R3: With cellMode = 1, cellOut takes the multiplexer result only on a rising edge of gateClk and holds it at all other times.
- R4: With cellMode = 1, 2 or 4, a low clearN forces every bit of cellOut to 0 at once, without waiting for gateClk, and it takes priority over an open latch.
- R5: With cellMode = 2, cellOut follows the multiplexer result while gateClk is high and keeps the value it had when gateClk fell while gateClk is low.
- R6: With cellMode = 3 the latch behaves as in R5, and clearN has no effect on cellOut.
- R7: With cellMode = 4 a clearable latch is fed by a 2-to-1 multiplexer. selLo = 0 picks dIn00 and selLo = 1 picks dIn01, and selHi, dIn10 and dIn11 have no effect on cellOut.
- R8: cellMode codes 5, 6 and 7 behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gateClk | input | 1 | Rising-edge clock for the flip-flop; active-high gate for the latch |
| clearN | input | 1 | Asynchronous active-low clear |
| cellMode | input | 3 | Static configuration code (0 to 7) |
| dIn00 | input | WIDTH | Data word picked by select 00 |
| dIn01 | input | WIDTH | Data word picked by select 01 |
| dIn10 | input | WIDTH | Data word picked by select 10 |
| dIn11 | input | WIDTH | Data word picked by select 11 |
| selHi | input | 1 | More significant select |
| selLo | input | 1 | Less significant select; the only select in reduced mode |
| cellOut | output | WIDTH | Cell result |

## Verification
The properties assume that data, selects, clearN and cellMode never change at a gateClk edge. They also assume that the mode stays fixed long enough for a held value to be meaningful, so the hold checks only fire when the mode has not changed since the last falling edge. The scoreboard drives each new input set one time unit after a falling edge, while the gate is low. It may apply a second set in the middle of the high phase, well clear of both edges, and it holds clearN for whole cycles. The first early-phase sample after a mode change is not compared, because the stored value left by the previous mode is not defined by the requirements.

// File: rtl/cell_pkg.sv
package cell_pkg;

  typedef enum logic [2:0] {
    MODE_COMB       = 3'd0,
    MODE_FLOP       = 3'd1,
    MODE_LATCH_CLR  = 3'd2,
    MODE_LATCH_HOLD = 3'd3,
    MODE_NARROW     = 3'd4
  } cellMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic useNarrow;   // 2-to-1 multiplexer feeds storage
    logic takeFlop;    // output from flip-flop
    logic takeLatch;   // output from latch
    logic latchClrEn;  // clear reaches the latch
  } ctrlStrobes_t;

endpackage

// File: rtl/cell_ctrl.sv
module cell_ctrl
  import cell_pkg::*;
(
  input  logic [2:0]   cellMode,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    case (cellMode)
      MODE_FLOP: begin
        strobes.takeFlop = 1'b1;
      end
      MODE_LATCH_CLR: begin
        strobes.takeLatch  = 1'b1;
        strobes.latchClrEn = 1'b1;
      end
      MODE_LATCH_HOLD: begin
        strobes.takeLatch = 1'b1;
      end
      MODE_NARROW: begin
        strobes.useNarrow  = 1'b1;
        strobes.takeLatch  = 1'b1;
        strobes.latchClrEn = 1'b1;
      end
      default: begin
        // combinational and reserved codes: plain pass-through
        strobes = '0;
      end
    endcase
  end

endmodule

// File: rtl/cell_datapath.sv
module cell_datapath
  import cell_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             gateClk,
  input  logic             clearN,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] dIn00,
  input  logic [WIDTH-1:0] dIn01,
  input  logic [WIDTH-1:0] dIn10,
  input  logic [WIDTH-1:0] dIn11,
  input  logic             selHi,
  input  logic             selLo,
  output logic [WIDTH-1:0] cellOut
);

  localparam logic [WIDTH-1:0] ZERO_WORD = '0;

  logic [WIDTH-1:0] wideMux;
  logic [WIDTH-1:0] narrowMux;
  logic [WIDTH-1:0] funcOut;
  logic [WIDTH-1:0] flopQ;
  logic [WIDTH-1:0] latchQ;
  logic             latchClr;

  // per-lane multiplexers
  for (genvar b = 0; b < WIDTH; b++) begin : gLane
    assign wideMux[b]   = selHi ? (selLo ? dIn11[b] : dIn10[b])
                                : (selLo ? dIn01[b] : dIn00[b]);
    assign narrowMux[b] = selLo ? dIn01[b] : dIn00[b];
  end

  assign funcOut = strobes.useNarrow ? narrowMux : wideMux;

  // edge storage with asynchronous clear
  always_ff @(posedge gateClk or negedge clearN) begin
    if (!clearN) flopQ <= ZERO_WORD;
    else         flopQ <= funcOut;
  end

  // level storage, clear only when enabled
  assign latchClr = !clearN && strobes.latchClrEn;

  always_latch begin
    if (latchClr)     latchQ = ZERO_WORD;
    else if (gateClk) latchQ = funcOut;
  end

  always_comb begin
    if (strobes.takeFlop)       cellOut = flopQ;
    else if (strobes.takeLatch) cellOut = latchQ;
    else                        cellOut = funcOut;
  end

endmodule

// File: rtl/mux_store_cell.sv
module mux_store_cell
  import cell_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             gateClk,
  input  logic             clearN,
  input  logic [2:0]       cellMode,
  input  logic [WIDTH-1:0] dIn00,
  input  logic [WIDTH-1:0] dIn01,
  input  logic [WIDTH-1:0] dIn10,
  input  logic [WIDTH-1:0] dIn11,
  input  logic             selHi,
  input  logic             selLo,
  output logic [WIDTH-1:0] cellOut
);

  ctrlStrobes_t strobes;

  cell_ctrl uCtrl (
    .cellMode (cellMode),
    .strobes  (strobes)
  );

  cell_datapath #(.WIDTH(WIDTH)) uData (
    .gateClk (gateClk),
    .clearN  (clearN),
    .strobes (strobes),
    .dIn00   (dIn00),
    .dIn01   (dIn01),
    .dIn10   (dIn10),
    .dIn11   (dIn11),
    .selHi   (selHi),
    .selLo   (selLo),
    .cellOut (cellOut)
  );

endmodule

// File: rtl/mux_store_cell_chk.sv
module mux_store_cell_chk #(
  parameter int WIDTH = 4
) (
  input logic             gateClk,
  input logic             clearN,
  input logic [2:0]       cellMode,
  input logic [WIDTH-1:0] dIn00,
  input logic [WIDTH-1:0] dIn01,
  input logic [WIDTH-1:0] dIn10,
  input logic [WIDTH-1:0] dIn11,
  input logic             selHi,
  input logic             selLo,
  input logic [WIDTH-1:0] cellOut
);

  logic [WIDTH-1:0] wideRef;
  logic [WIDTH-1:0] narrowRef;
  logic             clearingMode;
  logic             heldValid = 1'b0;
  logic [WIDTH-1:0] heldVal;
  logic [2:0]       heldMode;

  always_comb begin
    case ({selHi, selLo})
      2'b00:   wideRef = dIn00;
      2'b01:   wideRef = dIn01;
      2'b10:   wideRef = dIn10;
      default: wideRef = dIn11;
    endcase
    narrowRef    = selLo ? dIn01 : dIn00;
    clearingMode = (cellMode == 3'd1) || (cellMode == 3'd2) || (cellMode == 3'd4);
  end

  always_ff @(negedge gateClk) begin
    heldValid <= 1'b1;
    heldVal   <= cellOut;
    heldMode  <= cellMode;
  end

  AST_COMB_PASS: assert property (@(negedge gateClk) disable iff (!clearN)
    (cellMode == 3'd0) |-> (cellOut == wideRef)) else $error("comb mode"); // R2

  AST_FLOP_CAPTURE: assert property (@(posedge gateClk) disable iff (!clearN)
    ((cellMode == 3'd1) && $past(cellMode == 3'd1) && $past(clearN))
      |-> (cellOut == $past(wideRef))) else $error("flop capture"); // R3

  AST_LATCH_OPEN: assert property (@(negedge gateClk) disable iff (!clearN)
    (cellMode == 3'd2) |-> (cellOut == wideRef)) else $error("latch open"); // R5

  AST_NOCLR_HOLD: assert property (@(posedge gateClk) disable iff (!clearN)
    (heldValid && (heldMode == 3'd3) && (cellMode == 3'd3)) |-> (cellOut == heldVal))
    else $error("latch hold"); // R6

  AST_NARROW_SEL: assert property (@(negedge gateClk) disable iff (!clearN)
    (cellMode == 3'd4) |-> (cellOut == narrowRef)) else $error("narrow select"); // R7

  AST_RESERVED_PASS: assert property (@(negedge gateClk) disable iff (!clearN)
    (cellMode >= 3'd5) |-> (cellOut == wideRef)) else $error("reserved code"); // R8

  always @(negedge gateClk) begin
    if (clearN === 1'b0 && clearingMode) begin
      AST_CLEAR_ZERO: assert (cellOut == '0) else $error("clear"); // R4
    end
    if (cellMode === 3'd3) begin
      AST_NOCLR_OPEN: assert (cellOut == wideRef) else $error("no-clear latch"); // R6
    end
  end

endmodule

bind mux_store_cell mux_store_cell_chk #(.WIDTH(WIDTH)) uChk (
  .gateClk  (gateClk),
  .clearN   (clearN),
  .cellMode (cellMode),
  .dIn00    (dIn00),
  .dIn01    (dIn01),
  .dIn10    (dIn10),
  .dIn11    (dIn11),
  .selHi    (selHi),
  .selLo    (selLo),
  .cellOut  (cellOut)
);

// File: tb/mux_store_cell_test.sv
module mux_store_cell_test;

  localparam int W = 4;

  typedef struct {
    logic [2:0]   mode;
    logic         clrN;
    logic         hi;
    logic         lo;
    logic [W-1:0] d00, d01, d10, d11;
  } stim_t;

  typedef struct {
    logic [W-1:0] val;
    bit           chk;
    string        tag;
  } item_t;

  logic         gateClk = 1'b0;
  logic         clearN;
  logic [2:0]   cellMode;
  logic [W-1:0] dIn00, dIn01, dIn10, dIn11;
  logic         selHi, selLo;
  logic [W-1:0] cellOut;

  int    testsRun = 0;
  int    testsFailed = 0;
  bit    finished = 0;
  item_t expQ[$];

  logic [W-1:0] heldModel = '0;
  logic [2:0]   lastMode = 3'd0;
  bit           haveMode = 0;

  mux_store_cell #(.WIDTH(W)) uut (
    .gateClk(gateClk), .clearN(clearN), .cellMode(cellMode),
    .dIn00(dIn00), .dIn01(dIn01), .dIn10(dIn10), .dIn11(dIn11),
    .selHi(selHi), .selLo(selLo), .cellOut(cellOut)
  );

  always #5 gateClk = ~gateClk;

  function automatic stim_t mk(logic [2:0] m, logic c, logic h, logic l, logic [W-1:0] base);
    stim_t s;
    s.mode = m; s.clrN = c; s.hi = h; s.lo = l;
    s.d00 = base; s.d01 = base ^ 4'h5; s.d10 = base ^ 4'hA; s.d11 = base ^ 4'hF;
    return s;
  endfunction

  // R1 select order, R7 reduced multiplexer
  function automatic logic [W-1:0] muxOf(stim_t s);
    if (s.mode == 3'd4) return s.lo ? s.d01 : s.d00;
    case ({s.hi, s.lo})
      2'b00:   return s.d00;
      2'b01:   return s.d01;
      2'b10:   return s.d10;
      default: return s.d11;
    endcase
  endfunction

  task automatic apply(stim_t s);
    cellMode = s.mode; clearN = s.clrN; selHi = s.hi; selLo = s.lo;
    dIn00 = s.d00; dIn01 = s.d01; dIn10 = s.d10; dIn11 = s.d11;
  endtask

  // called one unit after a falling edge; a applied now, b mid high phase
  task automatic step(stim_t a, stim_t b, string tag);
    logic [W-1:0] muxA, muxB, e1, e2;
    bit firstOk;
    muxA = muxOf(a);
    muxB = muxOf(b);
    firstOk = haveMode && (lastMode == a.mode);
    case (a.mode)
      3'd1: begin
        if (!a.clrN) begin e1 = '0; e2 = '0; heldModel = '0; firstOk = 1; end
        else begin e1 = heldModel; e2 = muxA; heldModel = muxA; end
      end
      3'd2, 3'd4: begin
        if (!a.clrN) begin e1 = '0; e2 = '0; heldModel = '0; firstOk = 1; end
        else begin e1 = heldModel; e2 = muxB; heldModel = muxB; end
      end
      3'd3: begin
        e1 = heldModel; e2 = muxB; heldModel = muxB;
      end
      default: begin
        e1 = muxA; e2 = muxB; heldModel = muxB; firstOk = 1;
      end
    endcase
    lastMode = a.mode;
    haveMode = 1;
    expQ.push_back('{val: e1, chk: firstOk, tag: {tag, " early"}});
    expQ.push_back('{val: e2, chk: 1'b1,    tag: {tag, " late"}});
    apply(a);
    #6;
    apply(b);
    @(negedge gateClk);
    #1;
  endtask

  // monitor: samples at 4 and 9 units after each falling edge
  initial begin
    forever begin
      @(negedge gateClk);
      for (int k = 0; k < 2; k++) begin
        item_t it;
        #4;
        if (k == 1) #1;
        if (expQ.size() > 0) begin
          it = expQ.pop_front();
          if (it.chk) begin
            testsRun++;
            if (cellOut !== it.val) begin
              testsFailed++;
              $display("FAIL %s: actual %h expected %h", it.tag, cellOut, it.val);
            end
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    stim_t a, b;
    apply(mk(3'd1, 1'b0, 1'b0, 1'b0, 4'h1));
    @(negedge gateClk);
    #1;
    // R4 reset state in flop mode
    a = mk(3'd1, 1'b0, 1'b0, 1'b1, 4'h3);
    step(a, a, "R4 reset flop");
    // R3 flop captures, ignores high-phase change
    a = mk(3'd1, 1'b1, 1'b1, 1'b0, 4'h2);
    step(a, a, "R3 flop first");
    b = mk(3'd1, 1'b1, 1'b0, 1'b1, 4'h9);
    a = mk(3'd1, 1'b1, 1'b1, 1'b1, 4'h6);
    step(a, b, "R3 flop hold");
    a = mk(3'd1, 1'b1, 1'b0, 1'b0, 4'hC);
    step(a, a, "R3 flop next");
    a = mk(3'd1, 1'b0, 1'b0, 1'b0, 4'h7);
    step(a, a, "R4 flop clear");
    // R1 and R2: all selects, changes seen mid phase
    for (int s = 0; s < 4; s++) begin
      a = mk(3'd0, 1'b1, s[1], s[0], 4'(s * 3 + 1));
      b = mk(3'd0, 1'b1, ~s[1], s[0], 4'(s * 5 + 2));
      step(a, b, "R1 R2 comb select");
    end
    a = mk(3'd0, 1'b0, 1'b1, 1'b0, 4'h4);
    step(a, a, "R2 comb ignores clear");
    // R5 latch with clear
    a = mk(3'd2, 1'b1, 1'b0, 1'b1, 4'h8);
    step(a, a, "R5 latch first");
    b = mk(3'd2, 1'b1, 1'b1, 1'b1, 4'hB);
    a = mk(3'd2, 1'b1, 1'b1, 1'b0, 4'h1);
    step(a, b, "R5 latch follow");
    a = mk(3'd2, 1'b1, 1'b0, 1'b0, 4'hD);
    step(a, a, "R5 latch hold");
    a = mk(3'd2, 1'b0, 1'b1, 1'b1, 4'h5);
    step(a, a, "R4 latch clear");
    a = mk(3'd2, 1'b1, 1'b1, 1'b0, 4'h6);
    step(a, a, "R5 latch after clear");
    // R6 latch without clear
    a = mk(3'd3, 1'b1, 1'b0, 1'b1, 4'h2);
    step(a, a, "R6 noclr first");
    a = mk(3'd3, 1'b1, 1'b1, 1'b1, 4'hE);
    step(a, a, "R6 noclr hold");
    b = mk(3'd3, 1'b0, 1'b0, 1'b0, 4'h3);
    a = mk(3'd3, 1'b0, 1'b1, 1'b0, 4'h9);
    step(a, b, "R6 noclr ignores clear");
    a = mk(3'd3, 1'b0, 1'b0, 1'b1, 4'h4);
    step(a, a, "R6 noclr clear hold");
    // R7 reduced multiplexer; selHi, dIn10, dIn11 changed mid phase
    a = mk(3'd4, 1'b1, 1'b0, 1'b0, 4'h6);
    step(a, a, "R7 narrow first");
    for (int s = 0; s < 2; s++) begin
      a = mk(3'd4, 1'b1, 1'b0, s[0], 4'(s * 7 + 3));
      b = a;
      b.hi = 1'b1; b.d10 = ~a.d10; b.d11 = ~a.d11;
      step(a, b, "R7 narrow ignores upper");
    end
    a = mk(3'd4, 1'b0, 1'b1, 1'b1, 4'hA);
    step(a, a, "R4 narrow clear");
    // R8 reserved codes
    for (int m = 5; m < 8; m++) begin
      a = mk(3'(m), 1'b1, 1'b1, 1'(m), 4'(m));
      b = mk(3'(m), 1'b1, 1'b0, 1'(m), 4'(m + 8));
      step(a, b, "R8 reserved pass");
    end
    @(negedge gateClk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule